// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of a variable-length instruction decoder. Instruction bytes arrive one per cycle over a valid/ready stream. The scanner gathers the legacy prefixes and, in 64-bit mode, the REX prefixes. None of them is acted on as it arrives. Each one only updates a running record. When the first byte that is not a prefix arrives, the scanner resolves that record into a single summary for the instruction and then clears itself for the next instruction.

The summary gives:
- the operand-size flag and the address-size flag;
- the mandatory-prefix selector;
- the REX bits, with a flag saying whether a REX prefix is in force;
- the two-byte-map escape flag;
- the primary opcode byte;
- the number of prefixes;
- the byte offset of the opcode within the instruction;
- a length-fault flag.

Operand bytes beyond the opcode are not examined.

Back-pressure works as follows. An input byte is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high unless a summary is waiting and `out_ready_i` is low. A summary is offered with `out_valid_o`, and every summary field stays constant until `out_ready_i` is seen. When `out_ready_i` is held high, each summary appears as a one-cycle pulse.

Top module: `pfx_scan_top`

## Requirements
- R1: Reset state. After synchronous reset, `out_valid_o` is 0, `in_ready_o` is 1, and the next instruction starts with empty prefix state.
- R2: Legacy prefixes. Bytes 0x66, 0x67, 0xF2 and 0xF3 are counted in `out_pcount_o`. `out_opsz_o` is 1 if 0x66 appeared anywhere before the opcode. `out_adsz_o` is 1 if 0x67 appeared anywhere before the opcode.
- R3: REX prefixes and mode. Bytes 0x40 to 0x4F are REX prefixes only when `mode64_i` was 1 on the first byte of the instruction. Otherwise they are opcodes. Changes on `mode64_i` later within the same instruction have no effect.
- R4: Mandatory-prefix selector. `out_sel_o` is the last of 0x66, 0xF2 and 0xF3 in the stream, encoded as 0 = none, 1 = 0x66, 2 = 0xF2, 3 = 0xF3. An earlier 0xF3 is never dropped when it is the only one of the three.
- R5: REX reporting. A REX byte followed by any legacy prefix is cancelled, which sets `out_rex_valid_o` to 0. Otherwise the last REX byte's low nibble is reported on `out_rex_o`.
- R6: Escape. Byte 0x0F before the opcode sets `out_esc_o`. The byte after it is always taken as the opcode, whatever its value, even a prefix value.
- R7: Opcode offset. `out_offset_o` equals the prefix count plus 1 when the escape is present, or plus 0 when it is not.
- R8: Length fault. `out_fault_o` is 1 exactly when more than 14 prefix bytes preceded the opcode.
- R9: Back-pressure. While `out_valid_o` is 1 and `out_ready_i` is 0, `in_ready_o` is 0 and all summary outputs hold steady.
- R10: Timing and clearing. `out_valid_o` rises in the cycle after the opcode byte is accepted. With `out_ready_i` high it falls one cycle later. The next instruction starts from empty state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64_i | input | 1 | 1 = 64-bit decoding, sampled on each instruction's first byte |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Instruction byte |
| in_ready_o | output | 1 | Scanner can accept a byte |
| out_valid_o | output | 1 | Summary valid |
| out_ready_i | input | 1 | Consumer takes the summary |
| out_opsz_o | output | 1 | Operand-size override seen |
| out_adsz_o | output | 1 | Address-size override seen |
| out_sel_o | output | 2 | Mandatory-prefix selector (0 none, 1 0x66, 2 0xF2, 3 0xF3) |
| out_rex_valid_o | output | 1 | REX prefix in force |
| out_rex_o | output | 4 | REX low nibble |
| out_esc_o | output | 1 | Two-byte-map escape present |
| out_opcode_o | output | 8 | Primary opcode byte |
| out_pcount_o | output | 5 | Prefix count (saturating) |
| out_offset_o | output | 6 | Byte offset of the opcode |
| out_fault_o | output | 1 | Prefix run exceeds the length limit |

## Verification
Only one summary result exists per instruction. It is registered once, so it is due in the cycle after the rising edge that accepts the opcode byte. The bench drives bytes at falling edges and reads the summary at the next falling edge after the opcode's acceptance edge. It then confirms that the pulse is gone one falling edge later. While back-pressure is applied, the bench samples at several consecutive falling edges to confirm the held fields and the low `in_ready_o`. It also flips `mode64_i` after every instruction's first byte, so that a scanner that follows the mode mid-instruction gets a wrong summary.

// File: rtl/pfx_scan_pkg.sv
package pfx_scan_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_66   = 2'd1,
    SEL_F2   = 2'd2,
    SEL_F3   = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    BK_OPCODE = 2'd0,
    BK_LEGACY = 2'd1,
    BK_REX    = 2'd2,
    BK_ESCAPE = 2'd3
  } kind_e;

  localparam int unsigned LEG_N = 4;
  localparam logic [7:0] ESC_CODE = 8'h0F;
  localparam logic [3:0] REX_HI  = 4'h4;

  function automatic logic [7:0] leg_code(input int unsigned idx);
    case (idx)
      0:       return 8'h66;
      1:       return 8'h67;
      2:       return 8'hF2;
      default: return 8'hF3;
    endcase
  endfunction

  function automatic sel_e leg_sel(input int unsigned idx);
    case (idx)
      0:       return SEL_66;
      2:       return SEL_F2;
      3:       return SEL_F3;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_scan_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic       mode64_i,
  input  logic       after_esc_i,
  output kind_e      kind_o,
  output sel_e       sel_o,
  output logic       opsz_o,
  output logic       adsz_o
);

  logic [LEG_N-1:0] hit;
  sel_e             lane_sel [LEG_N];

  for (genvar g = 0; g < LEG_N; g++) begin : g_lane
    assign hit[g]      = (byte_i == leg_code(g));
    assign lane_sel[g] = hit[g] ? leg_sel(g) : SEL_NONE;
  end

  always_comb begin
    sel_o  = SEL_NONE;
    opsz_o = 1'b0;
    adsz_o = 1'b0;
    if (after_esc_i) begin
      kind_o = BK_OPCODE;
    end else if (|hit) begin
      kind_o = BK_LEGACY;
      opsz_o = hit[0];
      adsz_o = hit[1];
      for (int i = 0; i < LEG_N; i++) begin
        if (hit[i]) sel_o = lane_sel[i];
      end
    end else if (byte_i == ESC_CODE) begin
      kind_o = BK_ESCAPE;
    end else if (mode64_i && byte_i[7:4] == REX_HI) begin
      kind_o = BK_REX;
    end else begin
      kind_o = BK_OPCODE;
    end
  end

  always_comb begin
    a_one_lane_r2: assert ($countones(hit) <= 1);
  end

endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
  import pfx_scan_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned MAX_PFX = 14,
  localparam int unsigned OFS_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode64_i,
  input  logic             take_i,
  input  logic [7:0]       byte_i,
  output logic             done_o,
  output logic             opsz_o,
  output logic             adsz_o,
  output sel_e             sel_o,
  output logic             rex_v_o,
  output logic [3:0]       rex_o,
  output logic             esc_o,
  output logic [7:0]       opc_o,
  output logic [CNT_W-1:0] pcount_o,
  output logic [OFS_W-1:0] offset_o,
  output logic             fault_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(MAX_PFX);

  logic             busy_q, mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             opsz_q, adsz_q, rex_v_q, esc_q, flt_q;
  sel_e             sel_q;
  logic [3:0]       rex_q;

  logic  mode_eff;
  kind_e kind;
  sel_e  b_sel;
  logic  b_opsz, b_adsz;
  logic  is_pfx;
  logic [CNT_W-1:0] cnt_inc;

  assign mode_eff = busy_q ? mode_q : mode64_i;

  pfx_classify u_cls (
    .byte_i      (byte_i),
    .mode64_i    (mode_eff),
    .after_esc_i (esc_q),
    .kind_o      (kind),
    .sel_o       (b_sel),
    .opsz_o      (b_opsz),
    .adsz_o      (b_adsz)
  );

  assign is_pfx  = (kind == BK_LEGACY) || (kind == BK_REX);
  assign cnt_inc = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      mode_q  <= 1'b0;
      cnt_q   <= '0;
      opsz_q  <= 1'b0;
      adsz_q  <= 1'b0;
      sel_q   <= SEL_NONE;
      rex_v_q <= 1'b0;
      rex_q   <= '0;
      esc_q   <= 1'b0;
      flt_q   <= 1'b0;
    end else if (take_i) begin
      if (!busy_q) mode_q <= mode64_i;
      busy_q <= 1'b1;
      if (is_pfx) begin
        cnt_q <= cnt_inc;
        if (cnt_q >= CNT_LIM) flt_q <= 1'b1;
      end
      case (kind)
        BK_LEGACY: begin
          if (b_opsz) opsz_q <= 1'b1;
          if (b_adsz) adsz_q <= 1'b1;
          if (b_sel != SEL_NONE) sel_q <= b_sel;
          rex_v_q <= 1'b0;
        end
        BK_REX: begin
          rex_v_q <= 1'b1;
          rex_q   <= byte_i[3:0];
        end
        BK_ESCAPE: esc_q <= 1'b1;
        default: begin
          busy_q  <= 1'b0;
          cnt_q   <= '0;
          opsz_q  <= 1'b0;
          adsz_q  <= 1'b0;
          sel_q   <= SEL_NONE;
          rex_v_q <= 1'b0;
          rex_q   <= '0;
          esc_q   <= 1'b0;
          flt_q   <= 1'b0;
        end
      endcase
    end
  end

  assign done_o   = take_i && (kind == BK_OPCODE);
  assign opsz_o   = opsz_q;
  assign adsz_o   = adsz_q;
  assign sel_o    = sel_q;
  assign rex_v_o  = rex_v_q;
  assign rex_o    = rex_q;
  assign esc_o    = esc_q;
  assign opc_o    = byte_i;
  assign pcount_o = cnt_q;
  assign offset_o = OFS_W'(cnt_q) + OFS_W'(esc_q);
  assign fault_o  = flt_q;

  // R3: a live REX record implies the instruction was latched in 64-bit mode
  p_rex_mode_r3: assert property (@(posedge clk) disable iff (rst)
    rex_v_q |-> (busy_q && mode_q));

  // R10: accepting an opcode leaves the accumulator empty
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!busy_q && cnt_q == '0 && !esc_q && !rex_v_q && sel_q == SEL_NONE));

  // R6: an escape is followed by the opcode, never by another prefix
  p_esc_next_r6: assert property (@(posedge clk) disable iff (rst)
    (esc_q && take_i) |-> done_o);

  // R8: the fault flag can only be present with the count above the limit
  p_fault_cnt_r8: assert property (@(posedge clk) disable iff (rst)
    flt_q |-> (cnt_q > CNT_LIM));

endmodule

// File: rtl/pfx_out_reg.sv
module pfx_out_reg
  import pfx_scan_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned MAX_PFX = 14,
  localparam int unsigned OFS_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             ready_i,
  input  logic             opsz_i,
  input  logic             adsz_i,
  input  sel_e             sel_i,
  input  logic             rex_v_i,
  input  logic [3:0]       rex_i,
  input  logic             esc_i,
  input  logic [7:0]       opc_i,
  input  logic [CNT_W-1:0] pcount_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic             fault_i,
  output logic             valid_o,
  output logic             opsz_o,
  output logic             adsz_o,
  output sel_e             sel_o,
  output logic             rex_v_o,
  output logic [3:0]       rex_o,
  output logic             esc_o,
  output logic [7:0]       opc_o,
  output logic [CNT_W-1:0] pcount_o,
  output logic [OFS_W-1:0] offset_o,
  output logic             fault_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      opsz_o   <= 1'b0;
      adsz_o   <= 1'b0;
      sel_o    <= SEL_NONE;
      rex_v_o  <= 1'b0;
      rex_o    <= '0;
      esc_o    <= 1'b0;
      opc_o    <= '0;
      pcount_o <= '0;
      offset_o <= '0;
      fault_o  <= 1'b0;
    end else if (load_i) begin
      valid_o  <= 1'b1;
      opsz_o   <= opsz_i;
      adsz_o   <= adsz_i;
      sel_o    <= sel_i;
      rex_v_o  <= rex_v_i;
      rex_o    <= rex_i;
      esc_o    <= esc_i;
      opc_o    <= opc_i;
      pcount_o <= pcount_i;
      offset_o <= offset_i;
      fault_o  <= fault_i;
    end else if (ready_i) begin
      valid_o  <= 1'b0;
    end
  end

  // R9: a stalled summary keeps every field
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(opc_o) && $stable(sel_o)
                               && $stable(pcount_o) && $stable(rex_o)));

  // R7: offset relates to count and escape
  p_offset_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (offset_o == OFS_W'(pcount_o) + OFS_W'(esc_o)));

  // R8: fault tracks the prefix count limit
  p_fault_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (fault_o == (pcount_o > CNT_W'(MAX_PFX))));

  // R4: a 0x66 selector implies the operand-size flag
  p_sel_opsz_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && sel_o == SEL_66) |-> opsz_o);

  // R10: with the consumer ready and no new load, the pulse ends
  p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ready_i && !load_i) |=> !valid_o);

endmodule

// File: rtl/pfx_scan_top.sv
module pfx_scan_top
  import pfx_scan_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned MAX_PFX = 14,
  localparam int unsigned OFS_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode64_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_byte_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_opsz_o,
  output logic             out_adsz_o,
  output logic [1:0]       out_sel_o,
  output logic             out_rex_valid_o,
  output logic [3:0]       out_rex_o,
  output logic             out_esc_o,
  output logic [7:0]       out_opcode_o,
  output logic [CNT_W-1:0] out_pcount_o,
  output logic [OFS_W-1:0] out_offset_o,
  output logic             out_fault_o
);

  logic             take, done;
  logic             a_opsz, a_adsz, a_rex_v, a_esc, a_fault;
  sel_e             a_sel, o_sel;
  logic [3:0]       a_rex;
  logic [7:0]       a_opc;
  logic [CNT_W-1:0] a_pcount;
  logic [OFS_W-1:0] a_offset;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  pfx_accum #(.CNT_W(CNT_W), .MAX_PFX(MAX_PFX)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .mode64_i (mode64_i),
    .take_i   (take),
    .byte_i   (in_byte_i),
    .done_o   (done),
    .opsz_o   (a_opsz),
    .adsz_o   (a_adsz),
    .sel_o    (a_sel),
    .rex_v_o  (a_rex_v),
    .rex_o    (a_rex),
    .esc_o    (a_esc),
    .opc_o    (a_opc),
    .pcount_o (a_pcount),
    .offset_o (a_offset),
    .fault_o  (a_fault)
  );

  pfx_out_reg #(.CNT_W(CNT_W), .MAX_PFX(MAX_PFX)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load_i   (done),
    .ready_i  (out_ready_i),
    .opsz_i   (a_opsz),
    .adsz_i   (a_adsz),
    .sel_i    (a_sel),
    .rex_v_i  (a_rex_v),
    .rex_i    (a_rex),
    .esc_i    (a_esc),
    .opc_i    (a_opc),
    .pcount_i (a_pcount),
    .offset_i (a_offset),
    .fault_i  (a_fault),
    .valid_o  (out_valid_o),
    .opsz_o   (out_opsz_o),
    .adsz_o   (out_adsz_o),
    .sel_o    (o_sel),
    .rex_v_o  (out_rex_valid_o),
    .rex_o    (out_rex_o),
    .esc_o    (out_esc_o),
    .opc_o    (out_opcode_o),
    .pcount_o (out_pcount_o),
    .offset_o (out_offset_o),
    .fault_o  (out_fault_o)
  );

  assign out_sel_o = o_sel;

  // R9: no byte is accepted while a summary is stalled
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  // R10: the summary appears the cycle after the opcode is taken
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> out_valid_o);

  // R1: the cycle after reset carries no summary
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid_o);

endmodule

// File: tb/pfx_scan_top_tb_top.sv
module pfx_scan_top_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       mode64;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready;
  logic       o_opsz, o_adsz, o_rexv, o_esc, o_fault;
  logic [1:0] o_sel;
  logic [3:0] o_rex;
  logic [7:0] o_opc;
  logic [4:0] o_pcount;
  logic [5:0] o_offset;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done_run = 0;

  logic [7:0] sbuf [0:31];
  int         slen;

  always #2.5 clk = ~clk;

  pfx_scan_top dut_i (
    .clk             (clk),
    .rst             (rst),
    .mode64_i        (mode64),
    .in_valid_i      (in_valid),
    .in_byte_i       (in_byte),
    .in_ready_o      (in_ready),
    .out_valid_o     (out_valid),
    .out_ready_i     (out_ready),
    .out_opsz_o      (o_opsz),
    .out_adsz_o      (o_adsz),
    .out_sel_o       (o_sel),
    .out_rex_valid_o (o_rexv),
    .out_rex_o       (o_rex),
    .out_esc_o       (o_esc),
    .out_opcode_o    (o_opc),
    .out_pcount_o    (o_pcount),
    .out_offset_o    (o_offset),
    .out_fault_o     (o_fault)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_run) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  typedef struct {
    bit opsz, adsz, rv, esc, flt;
    int sel, rex, opc, pc, ofs;
  } exp_t;

  function automatic exp_t model(input bit m64);
    exp_t e;
    e = '{default: 0};
    for (int i = 0; i < slen; i++) begin
      int b = int'(sbuf[i]);
      if (e.esc) begin
        e.opc = b;
      end else if (b == 'h66 || b == 'h67 || b == 'hF2 || b == 'hF3) begin
        if (e.pc < 31) e.pc++;
        e.rv = 0;
        if (b == 'h66) begin e.opsz = 1; e.sel = 1; end
        if (b == 'h67) e.adsz = 1;
        if (b == 'hF2) e.sel = 2;
        if (b == 'hF3) e.sel = 3;
      end else if (b == 'h0F) begin
        e.esc = 1;
      end else if (m64 && b >= 'h40 && b <= 'h4F) begin
        if (e.pc < 31) e.pc++;
        e.rv  = 1;
        e.rex = b - 'h40;
      end else begin
        e.opc = b;
      end
    end
    e.flt = (e.pc > 14);
    e.ofs = e.pc + (e.esc ? 1 : 0);
    return e;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit m);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    mode64   = m;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // Sends sbuf; mode is flipped after the first byte to test sampling (R3).
  task automatic run_instr(input bit m64);
    exp_t e;
    e = model(m64);
    for (int i = 0; i < slen; i++) send_byte(sbuf[i], (i == 0) ? m64 : !m64);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R10", "valid after opcode", int'(out_valid), 1);
    chk(int'(o_opc) == e.opc, "R6", "opcode", int'(o_opc), e.opc);
    chk(o_esc == e.esc, "R6", "escape", int'(o_esc), int'(e.esc));
    chk(o_opsz == e.opsz && o_adsz == e.adsz, "R2", "size flags",
        int'({o_opsz, o_adsz}), int'({e.opsz, e.adsz}));
    chk(int'(o_pcount) == e.pc, "R2", "prefix count", int'(o_pcount), e.pc);
    chk(int'(o_sel) == e.sel, "R4", "selector", int'(o_sel), e.sel);
    chk(o_rexv == e.rv, "R3", "rex valid", int'(o_rexv), int'(e.rv));
    if (e.rv) chk(int'(o_rex) == e.rex, "R5", "rex bits", int'(o_rex), e.rex);
    chk(int'(o_offset) == e.ofs, "R7", "offset", int'(o_offset), e.ofs);
    chk(o_fault == e.flt, "R8", "fault", int'(o_fault), int'(e.flt));
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "pulse ends", int'(out_valid), 0);
  endtask

  localparam logic [7:0] PSET [6] = '{8'h66, 8'h67, 8'hF2, 8'hF3, 8'h41, 8'h4C};

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_byte = '0; mode64 = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);

    // R3/R6: every byte value alone, both modes
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        slen = 0;
        sbuf[slen++] = 8'(v);
        if (v == 'h66 || v == 'h67 || v == 'hF2 || v == 'hF3 || v == 'h0F
            || (m == 1 && v >= 'h40 && v <= 'h4F))
          sbuf[slen++] = 8'h90;
        run_instr(m[0]);
      end
    end

    // R2/R4/R5/R6: all prefix runs of length 0..3 from a six-byte set
    for (int m = 0; m < 2; m++)
      for (int n = 0; n <= 3; n++)
        for (int code = 0; code < 216; code++) begin
          int lim = (n == 0) ? 1 : (n == 1) ? 6 : (n == 2) ? 36 : 216;
          if (code < lim) begin
            for (int e = 0; e < 2; e++) begin
              int c = code;
              slen = 0;
              for (int k = 0; k < n; k++) begin
                sbuf[slen++] = PSET[c % 6];
                c = c / 6;
              end
              if (e == 1) begin
                sbuf[slen++] = 8'h0F;
                sbuf[slen++] = 8'h66;
              end else begin
                sbuf[slen++] = 8'h89;
              end
              run_instr(m[0]);
            end
          end
        end

    // R4/R5/R6: worked stream F3 66 F3 47 0F E6 in 64-bit mode
    slen = 0;
    sbuf[slen++] = 8'hF3; sbuf[slen++] = 8'h66; sbuf[slen++] = 8'hF3;
    sbuf[slen++] = 8'h47; sbuf[slen++] = 8'h0F; sbuf[slen++] = 8'hE6;
    run_instr(1'b1);

    // R8: fault boundary at 14, 15 and 20 prefixes
    for (int t = 0; t < 3; t++) begin
      int np = (t == 0) ? 14 : (t == 1) ? 15 : 20;
      slen = 0;
      for (int k = 0; k < np; k++) sbuf[slen++] = (k % 2) ? 8'h67 : 8'hF2;
      sbuf[slen++] = 8'hA5;
      run_instr(1'b0);
    end

    // R9: back-pressure holds summary and stalls input
    out_ready = 1'b0;
    send_byte(8'hF2, 1'b0);
    send_byte(8'hC3, 1'b0);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'h66;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid == 1'b1, "R9", "held valid", int'(out_valid), 1);
      chk(in_ready == 1'b0, "R9", "stalled ready", int'(in_ready), 0);
      chk(o_opc == 8'hC3 && o_sel == 2'd2, "R9", "held fields",
          int'(o_opc), 'hC3);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    send_byte(8'h90, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && o_opc == 8'h90, "R9", "resume opcode", int'(o_opc), 'h90);
    chk(o_sel == 2'd1 && o_opsz && o_pcount == 5'd1, "R10",
        "fresh state after stall", int'(o_pcount), 1);

    repeat (2) @(negedge clk);
    done_run = 1;
    finish_run();
  end

endmodule